// File: doc/BRIEF.md
# HDLC receive deframer with address filter

This block recovers HDLC frames from a serial bit stream that arrives one bit per strobe, least significant bit of each byte first. It finds the frame delimiters, drops the zeros a transmitter inserts after runs of five ones, detects aborted frames and checks the 16-bit frame check sequence. The first two bytes of each frame are compared against a board address and a broadcast address. Only frames that pass this filter reach the byte output.

Accepted frames leave the block as a byte stream. The address bytes come first and the payload follows. The two check bytes are removed. The first byte carries a start marker. A separate end strobe follows the frame and carries check-good, error and abort qualifiers. An abort also raises a one-cycle interrupt pulse. The address registers and the four compare enables are static inputs. They are expected to change only while no frame is in flight.

Top module: `hdlc_rx_filter`

## Requirements
- R1: During and right after reset, every output (out_vld, out_sof, out_end, out_fcs_ok, out_err, out_abort, abort_irq) is low.
- R2: The raw pattern 01111110 delimits frames. Two or more delimiters with no bits between them open and close no frame, so they produce no byte and no end strobe.
- R3: Two delimiters that share their middle 0 bit (011111101111110) are both recognised. A single delimiter between two frames closes the first frame and opens the second.
- R4: Inside a frame, a 0 that follows five consecutive 1s is discarded and never reaches the byte or check path.
- R5: Seven consecutive 1s inside an open frame abort it. abort_irq pulses exactly once, in the same cycle as an out_end with out_abort high, unless the frame was already rejected by the address filter. Runs of 1s while no frame is open raise nothing.
- R6: The check sequence uses polynomial x^16+x^12+x^5+1, processed LSB first with a preset of 0xFFFF. A frame that is long enough and byte-aligned ends with out_fcs_ok high exactly when the running remainder over all its bytes, check bytes included, equals 0xF0B8.
- R7: Enable bit 0 compares the first address byte with own_addr_first. Bit 1 compares the second address byte with own_addr_second. Bit 2 compares the first byte with bcast_addr_first. Bit 3 compares the second byte with bcast_addr_second. A target (board or broadcast) matches when at least one of its two bits is set and every enabled byte of it is equal. A frame is accepted when either target matches.
- R8: With all four enable bits clear, every frame is accepted whatever its first two bytes are.
- R9: A rejected frame yields no out_vld and no out_end.
- R10: An accepted frame yields, in order, its address bytes and its payload bytes, without the two check bytes. out_sof is set only on the first byte. One out_end follows, no earlier than the last byte.
- R11: A frame that closes with fewer than MIN_FRAME_BYTES whole bytes (default 4) or with a partial byte ends with out_err high and out_fcs_ok low. A frame that closes before its third byte is reported this way whatever its address.
- R12: Every output event appears two clock edges after the edge that samples the bit causing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | Strobe: bit_in holds a new line bit |
| bit_in | input | 1 | Serial line bit |
| own_addr_first | input | 8 | Board address, first byte |
| own_addr_second | input | 8 | Board address, second byte |
| bcast_addr_first | input | 8 | Broadcast address, first byte |
| bcast_addr_second | input | 8 | Broadcast address, second byte |
| addr_cmp_en | input | 4 | Compare enables, mapping as in R7 |
| out_vld | output | 1 | out_byte holds an accepted frame byte |
| out_byte | output | 8 | Accepted frame byte |
| out_sof | output | 1 | Marks the first byte of a frame |
| out_end | output | 1 | End-of-frame strobe |
| out_fcs_ok | output | 1 | With out_end: check sequence good |
| out_err | output | 1 | With out_end: frame too short or not byte-aligned |
| out_abort | output | 1 | With out_end: frame ended by an abort |
| abort_irq | output | 1 | One-cycle abort interrupt pulse |

## Verification
Every result is due two clock edges after the edge that samples the bit causing it: one edge for the line-bit stage and one for the byte stage. A byte and the end strobe can therefore land in the same cycle as the closing delimiter's last bit. Frame checks do not depend on that exact cycle. A negedge monitor collects every byte and end event, and each frame is judged only after its closing delimiter plus several idle cycles. The abort pulse is timed exactly: it must be low one edge after the seventh 1 is sampled and high one edge later. Assertions hold all output events to the same two-edge distance from a sampled bit.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
    localparam int          CRC_W        = 16;
    localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_LSB = 16'h8408;
    localparam logic [15:0] CRC_GOOD     = 16'hF0B8;
    localparam logic [7:0]  FLAG_PAT     = 8'h7E;

    typedef enum logic [1:0] {ADR_WAIT, ADR_PASS, ADR_DROP} adr_state_e;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        crc_step = (c >> 1) ^ (((c[0] ^ b) == 1'b1) ? CRC_POLY_LSB : 16'h0000);
    endfunction
endpackage

// File: rtl/hdlc_rx_bitproc.sv
// Line-bit stage: delimiter and abort detection, stuffed-zero removal.
// A raw window the length of the delimiter delays data bits so that
// delimiter bits never leak into the frame.
module hdlc_rx_bitproc
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    output logic dbit_vld,
    output logic dbit,
    output logic flag_p,
    output logic was_open,
    output logic abort_p
);
    localparam int WIN    = $bits(FLAG_PAT);
    localparam int ONES_W = $clog2(WIN);
    localparam logic [ONES_W-1:0] RUN_MAX   = ONES_W'(WIN - 1);
    localparam logic [ONES_W-1:0] RUN_PRE   = ONES_W'(WIN - 2);
    localparam logic [ONES_W-1:0] RUN_STUFF = ONES_W'(WIN - 3);

    typedef struct packed {
        logic [WIN-1:0]    win;
        logic [WIN-1:0]    keep;
        logic [ONES_W-1:0] ones;
        logic              open;
        logic              dv;
        logic              db;
        logic              flag;
        logic              was_open;
        logic              abort;
    } bp_state_t;

    bp_state_t st_d, st_q;
    logic      stuffed, hit_abort;

    always_comb begin
        st_d          = st_q;
        st_d.dv       = 1'b0;
        st_d.flag     = 1'b0;
        st_d.abort    = 1'b0;
        st_d.was_open = st_q.open;
        stuffed       = 1'b0;
        hit_abort     = 1'b0;
        if (bit_vld) begin
            stuffed   = !bit_in && (st_q.ones == RUN_STUFF);
            hit_abort = bit_in && (st_q.ones == RUN_PRE);
            st_d.win  = {st_q.win[WIN-2:0], bit_in};
            st_d.keep = {st_q.keep[WIN-2:0], !stuffed};
            if (!bit_in)
                st_d.ones = '0;
            else if (st_q.ones != RUN_MAX)
                st_d.ones = st_q.ones + 1'b1;
            st_d.dv = st_q.keep[WIN-1] && st_q.open && !hit_abort;
            st_d.db = st_q.win[WIN-1];
            if (st_d.win == FLAG_PAT) begin
                st_d.flag = 1'b1;
                st_d.keep = '0;
                st_d.open = 1'b1;
            end else if (hit_abort) begin
                st_d.abort = st_q.open;
                st_d.keep  = '0;
                st_d.open  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dbit_vld = st_q.dv;
    assign dbit     = st_q.db;
    assign flag_p   = st_q.flag;
    assign was_open = st_q.was_open;
    assign abort_p  = st_q.abort;
endmodule

// File: rtl/hdlc_addr_match.sv
// Combinational address filter: one comparator pair per target.
module hdlc_addr_match #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] adr_first,
    input  logic [BYTE_W-1:0] adr_second,
    input  logic [BYTE_W-1:0] own_first,
    input  logic [BYTE_W-1:0] own_second,
    input  logic [BYTE_W-1:0] bc_first,
    input  logic [BYTE_W-1:0] bc_second,
    input  logic [3:0]        cmp_en,
    output logic              adr_hit
);
    localparam int N_TGT = 2;

    logic [N_TGT-1:0][1:0][BYTE_W-1:0] tgt_ref;
    logic [N_TGT-1:0]                  tgt_hit;

    assign tgt_ref[0] = {own_second, own_first};
    assign tgt_ref[1] = {bc_second, bc_first};

    for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
        assign tgt_hit[g] = (|cmp_en[2*g+1 -: 2])
                          && (!cmp_en[2*g]   || (adr_first  == tgt_ref[g][0]))
                          && (!cmp_en[2*g+1] || (adr_second == tgt_ref[g][1]));
    end

    assign adr_hit = (cmp_en == 4'b0000) || (|tgt_hit);
endmodule

// File: rtl/hdlc_rx_bytepath.sv
// Byte stage: assembly, check sequence, two-byte holding line that both
// buffers the address for the filter decision and trims the check bytes.
module hdlc_rx_bytepath
    import hdlc_rx_pkg::*;
#(
    parameter int MIN_FRAME_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dbit_vld,
    input  logic       dbit,
    input  logic       flag_p,
    input  logic       was_open,
    input  logic       abort_p,
    input  logic       adr_hit,
    output logic [7:0] adr_first,
    output logic [7:0] adr_second,
    output logic       out_vld,
    output logic [7:0] out_byte,
    output logic       out_sof,
    output logic       out_end,
    output logic       out_fcs_ok,
    output logic       out_err,
    output logic       out_abort,
    output logic       abort_irq
);
    localparam int BYTE_W    = 8;
    localparam int BIT_W     = $clog2(BYTE_W);
    localparam int FCS_BYTES = CRC_W / BYTE_W;
    localparam int CNT_W     = $clog2(MIN_FRAME_BYTES + 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] DECIDE_AT = CNT_W'(FCS_BYTES);
    localparam logic [CNT_W-1:0] CNT_CAP   = CNT_W'(MIN_FRAME_BYTES);

    typedef struct packed {
        logic [BYTE_W-1:0]                 sh;
        logic [BIT_W-1:0]                  bitcnt;
        logic [CNT_W-1:0]                  nbytes;
        logic [CRC_W-1:0]                  crc;
        adr_state_e                        adr;
        logic [FCS_BYTES-1:0][BYTE_W-1:0]  held;
        logic                              o_vld;
        logic [BYTE_W-1:0]                 o_byte;
        logic                              o_sof;
        logic                              o_end;
        logic                              o_fcs;
        logic                              o_err;
        logic                              o_abt;
        logic                              o_irq;
    } by_state_t;

    by_state_t st_d, st_q;
    logic      bad_len;

    always_comb begin
        st_d       = st_q;
        st_d.o_vld = 1'b0;
        st_d.o_sof = 1'b0;
        st_d.o_end = 1'b0;
        st_d.o_fcs = 1'b0;
        st_d.o_err = 1'b0;
        st_d.o_abt = 1'b0;
        st_d.o_irq = 1'b0;
        bad_len    = 1'b0;
        if (dbit_vld) begin
            st_d.crc = crc_step(st_q.crc, dbit);
            st_d.sh  = {dbit, st_q.sh[BYTE_W-1:1]};
            if (st_q.bitcnt == LAST_BIT) begin
                st_d.bitcnt = '0;
                if (st_q.nbytes == DECIDE_AT && st_q.adr == ADR_WAIT)
                    st_d.adr = adr_hit ? ADR_PASS : ADR_DROP;
                if (st_q.nbytes >= DECIDE_AT && st_d.adr == ADR_PASS) begin
                    st_d.o_vld  = 1'b1;
                    st_d.o_byte = st_q.held[FCS_BYTES-1];
                    st_d.o_sof  = (st_q.nbytes == DECIDE_AT);
                end
                st_d.held = {st_q.held[FCS_BYTES-2:0], st_d.sh};
                if (st_q.nbytes != CNT_CAP)
                    st_d.nbytes = st_q.nbytes + 1'b1;
            end else begin
                st_d.bitcnt = st_q.bitcnt + 1'b1;
            end
        end
        if (flag_p) begin
            if (was_open && (st_d.nbytes != '0 || st_d.bitcnt != '0)
                && st_d.adr != ADR_DROP) begin
                bad_len    = (st_d.bitcnt != '0) || (st_d.nbytes < CNT_CAP);
                st_d.o_end = 1'b1;
                st_d.o_err = bad_len;
                st_d.o_fcs = !bad_len && (st_d.crc == CRC_GOOD);
            end
        end
        if (abort_p) begin
            st_d.o_irq = 1'b1;
            if (st_d.adr != ADR_DROP) begin
                st_d.o_end = 1'b1;
                st_d.o_abt = 1'b1;
            end
        end
        if (flag_p || abort_p) begin
            st_d.bitcnt = '0;
            st_d.nbytes = '0;
            st_d.crc    = CRC_PRESET;
            st_d.adr    = ADR_WAIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.crc <= CRC_PRESET;
            st_q.adr <= ADR_WAIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign adr_first  = st_q.held[FCS_BYTES-1];
    assign adr_second = st_q.held[FCS_BYTES-2];
    assign out_vld    = st_q.o_vld;
    assign out_byte   = st_q.o_byte;
    assign out_sof    = st_q.o_sof;
    assign out_end    = st_q.o_end;
    assign out_fcs_ok = st_q.o_fcs;
    assign out_err    = st_q.o_err;
    assign out_abort  = st_q.o_abt;
    assign abort_irq  = st_q.o_irq;
endmodule

// File: rtl/hdlc_rx_filter.sv
module hdlc_rx_filter #(
    parameter int MIN_FRAME_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_vld,
    input  logic       bit_in,
    input  logic [7:0] own_addr_first,
    input  logic [7:0] own_addr_second,
    input  logic [7:0] bcast_addr_first,
    input  logic [7:0] bcast_addr_second,
    input  logic [3:0] addr_cmp_en,
    output logic       out_vld,
    output logic [7:0] out_byte,
    output logic       out_sof,
    output logic       out_end,
    output logic       out_fcs_ok,
    output logic       out_err,
    output logic       out_abort,
    output logic       abort_irq
);
    logic       dbit_vld, dbit, flag_p, was_open, abort_p, adr_hit;
    logic [7:0] adr_first, adr_second;

    hdlc_rx_bitproc bit_i (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .dbit_vld(dbit_vld), .dbit(dbit), .flag_p(flag_p),
        .was_open(was_open), .abort_p(abort_p)
    );

    hdlc_addr_match #(.BYTE_W(8)) match_i (
        .adr_first(adr_first), .adr_second(adr_second),
        .own_first(own_addr_first), .own_second(own_addr_second),
        .bc_first(bcast_addr_first), .bc_second(bcast_addr_second),
        .cmp_en(addr_cmp_en), .adr_hit(adr_hit)
    );

    hdlc_rx_bytepath #(.MIN_FRAME_BYTES(MIN_FRAME_BYTES)) byte_i (
        .clk(clk), .rst_n(rst_n), .dbit_vld(dbit_vld), .dbit(dbit),
        .flag_p(flag_p), .was_open(was_open), .abort_p(abort_p),
        .adr_hit(adr_hit), .adr_first(adr_first), .adr_second(adr_second),
        .out_vld(out_vld), .out_byte(out_byte), .out_sof(out_sof),
        .out_end(out_end), .out_fcs_ok(out_fcs_ok), .out_err(out_err),
        .out_abort(out_abort), .abort_irq(abort_irq)
    );
endmodule

// File: rtl/hdlc_rx_filter_chk.sv
module hdlc_rx_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_vld,
    input logic bit_in,
    input logic out_vld,
    input logic out_sof,
    input logic out_end,
    input logic out_fcs_ok,
    input logic out_err,
    input logic out_abort,
    input logic abort_irq
);
    AST_SOF_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_vld); // R10
    AST_FCS_OK_CLEAN_END: assert property (@(posedge clk) disable iff (!rst_n)
        out_fcs_ok |-> (out_end && !out_err && !out_abort)); // R6
    AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_end); // R11
    AST_ABORT_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        out_abort |-> (out_end && abort_irq)); // R5
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_irq |=> !abort_irq); // R5
    AST_IRQ_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_irq |-> !out_vld); // R5
    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        abort_irq |-> ($past(bit_vld, 2) && $past(bit_in, 2))); // R12
    AST_BYTE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(bit_vld, 2)); // R12
    AST_END_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_end |-> $past(bit_vld, 2)); // R12
endmodule

bind hdlc_rx_filter hdlc_rx_filter_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .out_vld(out_vld), .out_sof(out_sof), .out_end(out_end),
    .out_fcs_ok(out_fcs_ok), .out_err(out_err), .out_abort(out_abort),
    .abort_irq(abort_irq)
);

// File: tb/hdlc_rx_filter_tb_top.sv
`timescale 1ns/1ps
module hdlc_rx_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b1;
    logic [7:0] own_first = 8'h12, own_second = 8'h34;
    logic [7:0] bc_first = 8'hFF, bc_second = 8'hFF;
    logic [3:0] cmp_en = 4'h0;
    logic       out_vld, out_sof, out_end, out_fcs_ok, out_err, out_abort, abort_irq;
    logic [7:0] out_byte;

    always #2.5 clk = ~clk;

    hdlc_rx_filter dut_i (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .own_addr_first(own_first), .own_addr_second(own_second),
        .bcast_addr_first(bc_first), .bcast_addr_second(bc_second),
        .addr_cmp_en(cmp_en), .out_vld(out_vld), .out_byte(out_byte),
        .out_sof(out_sof), .out_end(out_end), .out_fcs_ok(out_fcs_ok),
        .out_err(out_err), .out_abort(out_abort), .abort_irq(abort_irq)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // monitor
    logic [7:0] rxb [0:63];
    int rxn, sofn, sofpos, endn, irqn;
    logic last_fcs, last_err, last_abt;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_vld) begin
                if (rxn < 64) rxb[rxn] = out_byte;
                if (out_sof) begin sofn++; sofpos = rxn; end
                rxn++;
            end
            if (out_end) begin
                endn++;
                last_fcs = out_fcs_ok;
                last_err = out_err;
                last_abt = out_abort;
            end
            if (abort_irq) irqn++;
        end
    end

    task automatic clear_mon();
        rxn = 0; sofn = 0; sofpos = -1; endn = 0;
        last_fcs = 1'b0; last_err = 1'b0; last_abt = 1'b0;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // transmitter model
    int tx_gap = 0;
    int tx_ones = 0;
    logic [7:0] fbuf [0:15];

    task automatic tx_raw(input logic b);
        bit_in = b;
        bit_vld = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
        repeat (tx_gap) @(negedge clk);
    endtask

    task automatic tx_flag();
        for (int i = 0; i < 8; i++) tx_raw(8'h7E >> i);
        tx_ones = 0;
    endtask

    task automatic tx_dbit(input logic b);
        tx_raw(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin tx_raw(1'b0); tx_ones = 0; end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic tx_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) tx_dbit(v[i]);
    endtask

    function automatic logic [15:0] fcs_of(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++)
            for (int k = 0; k < 8; k++)
                c = (c >> 1) ^ (((c[0] ^ fbuf[i][k]) == 1'b1) ? 16'h8408 : 16'h0000);
        return ~c;
    endfunction

    task automatic tx_frame(input int n, input bit bad);
        logic [15:0] f;
        f = fcs_of(n) ^ (bad ? 16'h0001 : 16'h0000);
        for (int i = 0; i < n; i++) tx_byte(fbuf[i]);
        tx_byte(f[7:0]);
        tx_byte(f[15:8]);
    endtask

    task automatic fill(input logic [7:0] a0, input logic [7:0] a1, input int plen);
        fbuf[0] = a0;
        fbuf[1] = a1;
        for (int j = 0; j < plen; j++) fbuf[2 + j] = 8'h7E ^ 8'(j * 129);
    endtask

    function automatic int mismatches(input int n);
        int m = 0;
        for (int i = 0; i < n; i++) if (rxb[i] != fbuf[i]) m++;
        return m;
    endfunction

    // {cmp_en, first, second, payload length, expect accept, gapped}
    localparam logic [24:0] VEC [9] = '{
        {4'hF, 8'h12, 8'h34, 3'd2, 1'b1, 1'b0},
        {4'hF, 8'hFF, 8'hFF, 3'd3, 1'b1, 1'b1},
        {4'hF, 8'h12, 8'h35, 3'd1, 1'b0, 1'b0},
        {4'h0, 8'h55, 8'h66, 3'd2, 1'b1, 1'b0},
        {4'h1, 8'h12, 8'h99, 3'd0, 1'b1, 1'b1},
        {4'h4, 8'h12, 8'h34, 3'd1, 1'b0, 1'b0},
        {4'h3, 8'hFF, 8'hFF, 3'd2, 1'b0, 1'b0},
        {4'hC, 8'hFF, 8'h00, 3'd1, 1'b0, 1'b1},
        {4'h5, 8'hFF, 8'h77, 3'd3, 1'b1, 1'b0}
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int plen, n;
        bit acc;
        clear_mon();
        irqn = 0;
        repeat (3) @(negedge clk);
        chk({out_vld, out_sof, out_end, out_fcs_ok, out_err, out_abort, abort_irq} == 7'b0,
            "R1 outputs in reset", int'({out_vld, out_end, abort_irq}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({out_vld, out_sof, out_end, out_fcs_ok, out_err, out_abort, abort_irq} == 7'b0,
            "R1 outputs after reset", int'({out_vld, out_end, abort_irq}), 0);

        // R2: back-to-back delimiters give nothing
        tx_flag(); tx_flag(); tx_flag();
        repeat (4) @(negedge clk);
        chk(rxn == 0 && endn == 0, "R2 empty delimiters", rxn + endn, 0);

        // table: each frame closed by one delimiter that opens the next (R3)
        foreach (VEC[v]) begin
            clear_mon();
            cmp_en = VEC[v][24:21];
            plen   = int'(VEC[v][4:2]);
            acc    = VEC[v][1];
            tx_gap = VEC[v][0] ? 1 : 0;
            n      = 2 + plen;
            fill(VEC[v][20:13], VEC[v][12:5], plen);
            tx_frame(n, 1'b0);
            tx_flag();
            tx_gap = 0;
            repeat (6) @(negedge clk);
            if (acc) begin
                chk(rxn == n, $sformatf("R10 R7 R8 byte count vec %0d", v), rxn, n);
                chk(mismatches(n) == 0, $sformatf("R4 R10 byte content vec %0d", v), mismatches(n), 0);
                chk(sofn == 1 && sofpos == 0, $sformatf("R10 start marker vec %0d", v), sofpos, 0);
                chk(endn == 1 && last_fcs && !last_err, $sformatf("R6 R3 clean end vec %0d", v),
                    int'({endn[1:0], last_fcs, last_err}), 4'b0110);
            end else begin
                chk(rxn == 0 && endn == 0, $sformatf("R9 R7 rejected vec %0d", v), rxn + endn, 0);
            end
        end

        // R3: two delimiters sharing a zero, then a frame
        cmp_en = 4'h0;
        clear_mon();
        tx_flag();
        for (int i = 0; i < 6; i++) tx_raw(1'b1);
        tx_raw(1'b0);
        tx_ones = 0;
        fill(8'hA1, 8'hB2, 1);
        tx_frame(3, 1'b0);
        tx_flag();
        repeat (6) @(negedge clk);
        chk(rxn == 3 && mismatches(3) == 0, "R3 shared-zero delimiters", rxn, 3);
        chk(endn == 1 && last_fcs, "R3 R6 shared-zero end", endn, 1);

        // R6: corrupted check sequence
        clear_mon();
        fill(8'h01, 8'h02, 2);
        tx_frame(4, 1'b1);
        tx_flag();
        repeat (6) @(negedge clk);
        chk(endn == 1 && !last_fcs && !last_err, "R6 bad check sequence",
            int'({last_fcs, last_err}), 0);

        // R11: three whole bytes only
        clear_mon();
        tx_byte(8'h12); tx_byte(8'h34); tx_byte(8'hAA);
        tx_flag();
        repeat (6) @(negedge clk);
        chk(endn == 1 && last_err && !last_fcs, "R11 short frame", int'({last_err, last_fcs}), 2);
        chk(rxn == 1 && rxb[0] == 8'h12, "R11 short frame bytes", rxn, 1);

        // R11: good frame plus a partial byte
        clear_mon();
        fill(8'h21, 8'h43, 1);
        tx_frame(3, 1'b0);
        tx_dbit(1'b0); tx_dbit(1'b1); tx_dbit(1'b0);
        tx_flag();
        repeat (6) @(negedge clk);
        chk(endn == 1 && last_err && !last_fcs, "R11 unaligned frame", int'({last_err, last_fcs}), 2);

        // R5 / R12: abort timing
        clear_mon();
        irqn = 0;
        tx_byte(8'h12); tx_byte(8'h34);
        for (int i = 0; i < 6; i++) tx_raw(1'b1);
        tx_raw(1'b1);
        chk(abort_irq == 1'b0, "R12 abort not before two edges", int'(abort_irq), 0);
        @(negedge clk);
        chk(abort_irq == 1'b1, "R5 R12 abort pulse on second edge", int'(abort_irq), 1);
        for (int i = 0; i < 10; i++) tx_raw(1'b1);
        repeat (4) @(negedge clk);
        chk(irqn == 1, "R5 single abort pulse", irqn, 1);
        chk(endn == 1 && last_abt, "R5 abort end marker", int'({endn[1:0], last_abt}), 3);
        tx_ones = 0;

        // R5: ones on an idle line raise nothing
        irqn = 0;
        for (int i = 0; i < 12; i++) tx_raw(1'b1);
        repeat (4) @(negedge clk);
        chk(irqn == 0, "R5 idle ones no abort", irqn, 0);

        // recovery after abort
        clear_mon();
        tx_flag();
        fill(8'h12, 8'h34, 2);
        tx_frame(4, 1'b0);
        tx_flag();
        repeat (6) @(negedge clk);
        chk(rxn == 4 && mismatches(4) == 0 && last_fcs, "R2 R10 frame after abort", rxn, 4);

        finish_run();
    end
endmodule